// File: doc/BRIEF.md
# Cache range maintenance splitter

This block takes one maintenance request and turns it into a series of commands for a downstream line/range engine. A request is a byte range with an exclusive end and an operation: invalidate, clean, or flush (clean then invalidate). The block squares the range to cache-line boundaries and issues single-line commands for partial edge lines where the operation calls for them. It then walks the remaining whole lines in chunks. A chunk never grows past a fixed byte budget and never crosses a page boundary.

Commands go out one at a time under a valid/ready handshake. After a command is accepted, the block waits for the engine's done pulse before it presents the next. When the last command of a request has completed, the block raises a one-cycle barrier pulse. A write-through override flag, sampled with the request, removes the clean work, which cannot be needed when the cache never holds dirty data.

Top module: `maint_range_splitter`

## Requirements
- R1: After reset, req_ready is 1 and cmd_valid and barrier are 0. A request is taken when req_valid and req_ready are both 1. req_ready stays 0 from the cycle after a non-empty request is taken until its barrier pulse.
- R2: Whole lines are walked in chunks. A chunk starting at address S ends at the smallest of the walk end, S+1024 and the next 4096-byte page boundary above S. Its range command carries cmd_addr = S and cmd_last = chunk end − 32, an inclusive line address.
- R3: Command kinds are encoded on cmd_kind as 0 = single-line clean-and-invalidate, 1 = clean range and 2 = invalidate range. A single-line command has cmd_last equal to cmd_addr. For an invalidate request whose start is not 32-byte aligned, the first command is kind 0 at the start rounded down, and the walk begins at the next line boundary.
- R4: For an invalidate request, if the walk start is still below the request end and the end is not line aligned, a kind 0 command is issued for the end rounded down. It follows any head command and comes before all range commands. The walk end is the request end rounded down.
- R5: For clean and flush, the start is rounded down and the end rounded up to 32-byte boundaries before the walk. Every command address is line aligned.
- R6: For flush without override, each chunk issues a clean-range command followed by an invalidate-range command over the same lines.
- R7: With req_wt_override set at acceptance, a clean request issues no commands and a flush request issues only invalidate-range commands. The flag has no effect on invalidate.
- R8: barrier is a single-cycle pulse, exactly one per request. It is raised only after the done of the request's last command, and no command is valid while it is high.
- R9: A request whose start equals its end issues no commands. Its barrier is high in the cycle right after acceptance.
- R10: While cmd_valid is 1 and cmd_ready is 0, cmd_kind, cmd_addr and cmd_last hold. After acceptance, no new command is presented until cmd_done has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 2 | 0 invalidate, 1 clean, 2 flush |
| req_wt_override | input | 1 | Write-through override, sampled with the request |
| req_start | input | AW | First byte of the range |
| req_end | input | AW | Exclusive end byte of the range |
| cmd_valid | output | 1 | Command presented to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_kind | output | 2 | Command kind (see R3) |
| cmd_addr | output | AW | First line address |
| cmd_last | output | AW | Last line address, inclusive |
| cmd_done | input | 1 | Engine finished the accepted command |
| barrier | output | 1 | Request complete pulse |

## Verification
The assertions check, on every cycle, the properties that hold for each command on its own. A range command stays inside one page and within the byte budget, and all addresses are line aligned. A single-line command covers exactly one line. Fields hold while the engine stalls, nothing is presented before done, and no clean command appears under override. Only the bench's scenarios can show the rest: the exact order and count of commands for each request shape, the edge-line choices for invalidate, the clean/invalidate pairing for flush, and barrier timing (including the one-cycle completion of an empty request).

// File: rtl/msplit_pkg.sv
package msplit_pkg;
  localparam logic [1:0] OP_INV   = 2'd0;
  localparam logic [1:0] OP_CLEAN = 2'd1;
  localparam logic [1:0] OP_FLUSH = 2'd2;

  localparam logic [1:0] CK_LINE  = 2'd0;
  localparam logic [1:0] CK_CLEAN = 2'd1;
  localparam logic [1:0] CK_INV   = 2'd2;

  typedef enum logic {ST_IDLE, ST_RUN} msplit_state_e;
endpackage

// File: rtl/msplit_edge_prep.sv
module msplit_edge_prep #(
  parameter int AW = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic [1:0]    op,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          head_need,
  output logic [AW-1:0] head_addr,
  output logic          tail_need,
  output logic [AW-1:0] tail_addr,
  output logic [AW:0]   walk_lo,
  output logic [AW:0]   walk_hi
);
  import msplit_pkg::*;

  localparam int LB = $clog2(LINE_BYTES);
  localparam logic [AW:0] LINE_W = (AW+1)'(LINE_BYTES);

  logic [AW-1:0] s_down, e_down;
  logic          s_off, e_off;
  logic [AW:0]   e_up;
  logic [AW:0]   inv_lo;

  assign s_off  = |start_addr[LB-1:0];
  assign e_off  = |end_addr[LB-1:0];
  assign s_down = {start_addr[AW-1:LB], {LB{1'b0}}};
  assign e_down = {end_addr[AW-1:LB], {LB{1'b0}}};
  assign e_up   = {1'b0, e_down} + (e_off ? LINE_W : '0);
  assign inv_lo = s_off ? ({1'b0, s_down} + LINE_W) : {1'b0, start_addr};

  assign head_addr = s_down;
  assign tail_addr = e_down;

  always_comb begin
    if (op == OP_INV) begin
      head_need = s_off;
      tail_need = (inv_lo < {1'b0, end_addr}) && e_off;
      walk_lo   = inv_lo;
      walk_hi   = {1'b0, e_down};
    end else begin
      head_need = 1'b0;
      tail_need = 1'b0;
      walk_lo   = {1'b0, s_down};
      walk_hi   = e_up;
    end
  end
endmodule

// File: rtl/msplit_chunk_calc.sv
module msplit_chunk_calc #(
  parameter int AW = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic [AW:0]   cur,
  input  logic [AW:0]   lim,
  output logic [AW:0]   chunk_end,
  output logic [AW-1:0] last_addr
);
  localparam logic [AW:0]   PAGE_MASK = (AW+1)'(PAGE_BYTES - 1);
  localparam logic [AW:0]   MAX_W     = (AW+1)'(MAX_CHUNK_BYTES);
  localparam logic [AW-1:0] LINE_A    = AW'(LINE_BYTES);

  logic [AW:0] page_next;
  logic [AW:0] bound;

  assign page_next = (cur | PAGE_MASK) + 1'b1;

  generate
    if (MAX_CHUNK_BYTES < PAGE_BYTES) begin : g_cap
      logic [AW:0] cap;
      assign cap   = cur + MAX_W;
      assign bound = (cap < page_next) ? cap : page_next;
    end else begin : g_page_only
      assign bound = page_next;
    end
  endgenerate

  assign chunk_end = (lim < bound) ? lim : bound;
  assign last_addr = chunk_end[AW-1:0] - LINE_A;
endmodule

// File: rtl/msplit_cmd_port.sv
module msplit_cmd_port #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [1:0]    load_kind,
  input  logic [AW-1:0] load_addr,
  input  logic [AW-1:0] load_last,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] cmd_last,
  input  logic          cmd_done,
  output logic          busy
);
  logic wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      wait_q    <= 1'b0;
      cmd_kind  <= '0;
      cmd_addr  <= '0;
      cmd_last  <= '0;
    end else begin
      if (load) begin
        cmd_valid <= 1'b1;
        cmd_kind  <= load_kind;
        cmd_addr  <= load_addr;
        cmd_last  <= load_last;
      end else if (cmd_valid && cmd_ready) begin
        cmd_valid <= 1'b0;
        wait_q    <= 1'b1;
      end else if (wait_q && cmd_done) begin
        wait_q    <= 1'b0;
      end
    end
  end

  assign busy = cmd_valid | wait_q;

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_kind) && $stable(cmd_addr) && $stable(cmd_last)); // R10
  AST_WAIT_DONE: assert property (@(posedge clk) disable iff (rst)
    wait_q && !cmd_done |=> !cmd_valid); // R10
  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    load |-> !busy); // R10
endmodule

// File: rtl/maint_range_splitter.sv
module maint_range_splitter #(
  parameter int AW = 32,
  parameter int LINE_BYTES = 32,
  parameter int MAX_CHUNK_BYTES = 1024,
  parameter int PAGE_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic          req_wt_override,
  input  logic [AW-1:0] req_start,
  input  logic [AW-1:0] req_end,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [1:0]    cmd_kind,
  output logic [AW-1:0] cmd_addr,
  output logic [AW-1:0] cmd_last,
  input  logic          cmd_done,
  output logic          barrier
);
  import msplit_pkg::*;

  localparam int LB = $clog2(LINE_BYTES);
  localparam int PB = $clog2(PAGE_BYTES);
  localparam logic [AW-1:0] SPAN_MAX = AW'(MAX_CHUNK_BYTES - LINE_BYTES);

  msplit_state_e state_q;
  logic [1:0]    op_q;
  logic          wt_q;
  logic          head_q, tail_q, half_q, bar_q;
  logic [AW-1:0] haddr_q, taddr_q;
  logic [AW:0]   cur_q, lim_q;

  logic          e_head, e_tail;
  logic [AW-1:0] e_haddr, e_taddr;
  logic [AW:0]   e_lo, e_hi;
  logic [AW:0]   c_end;
  logic [AW-1:0] c_last;
  logic          port_busy;

  logic          ld;
  logic [1:0]    ld_kind;
  logic [AW-1:0] ld_addr, ld_last;
  logic          do_adv, do_half, finish;

  msplit_edge_prep #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_edge (
    .op(req_op), .start_addr(req_start), .end_addr(req_end),
    .head_need(e_head), .head_addr(e_haddr),
    .tail_need(e_tail), .tail_addr(e_taddr),
    .walk_lo(e_lo), .walk_hi(e_hi)
  );

  msplit_chunk_calc #(.AW(AW), .LINE_BYTES(LINE_BYTES),
                      .MAX_CHUNK_BYTES(MAX_CHUNK_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .cur(cur_q), .lim(lim_q), .chunk_end(c_end), .last_addr(c_last)
  );

  msplit_cmd_port #(.AW(AW)) u_port (
    .clk(clk), .rst(rst),
    .load(ld), .load_kind(ld_kind), .load_addr(ld_addr), .load_last(ld_last),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_last(cmd_last),
    .cmd_done(cmd_done), .busy(port_busy)
  );

  // next-command selection: head line, tail line, then chunks
  always_comb begin
    ld      = 1'b0;
    ld_kind = CK_LINE;
    ld_addr = '0;
    ld_last = '0;
    do_adv  = 1'b0;
    do_half = 1'b0;
    finish  = 1'b0;
    if (state_q == ST_RUN && !port_busy) begin
      if (head_q) begin
        ld      = 1'b1;
        ld_addr = haddr_q;
        ld_last = haddr_q;
      end else if (tail_q) begin
        ld      = 1'b1;
        ld_addr = taddr_q;
        ld_last = taddr_q;
      end else if (cur_q < lim_q) begin
        ld      = 1'b1;
        ld_addr = cur_q[AW-1:0];
        ld_last = c_last;
        if (op_q == OP_CLEAN) begin
          ld_kind = CK_CLEAN;
          do_adv  = 1'b1;
        end else if (op_q == OP_FLUSH && !wt_q && !half_q) begin
          ld_kind = CK_CLEAN;
          do_half = 1'b1;
        end else begin
          ld_kind = CK_INV;
          do_adv  = 1'b1;
        end
      end else begin
        finish = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_q    <= OP_INV;
      wt_q    <= 1'b0;
      head_q  <= 1'b0;
      tail_q  <= 1'b0;
      half_q  <= 1'b0;
      bar_q   <= 1'b0;
      haddr_q <= '0;
      taddr_q <= '0;
      cur_q   <= '0;
      lim_q   <= '0;
    end else begin
      bar_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (req_start == req_end) begin
              bar_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              op_q    <= req_op;
              wt_q    <= req_wt_override;
              head_q  <= e_head;
              tail_q  <= e_tail;
              haddr_q <= e_haddr;
              taddr_q <= e_taddr;
              half_q  <= 1'b0;
              cur_q   <= e_lo;
              lim_q   <= (req_op == OP_CLEAN && req_wt_override) ? e_lo : e_hi;
            end
          end
        end
        default: begin
          if (ld && head_q)      head_q <= 1'b0;
          else if (ld && tail_q) tail_q <= 1'b0;
          if (do_half) half_q <= 1'b1;
          if (do_adv) begin
            half_q <= 1'b0;
            cur_q  <= c_end;
          end
          if (finish) begin
            bar_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign barrier   = bar_q;

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !cmd_valid); // R1
  AST_CHUNK_PAGE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind != CK_LINE |-> cmd_addr[AW-1:PB] == cmd_last[AW-1:PB]); // R2
  AST_CHUNK_SIZE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind != CK_LINE |-> cmd_last >= cmd_addr && (cmd_last - cmd_addr) <= SPAN_MAX); // R2
  AST_LINE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_kind == CK_LINE |-> cmd_addr == cmd_last); // R3
  AST_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_addr[LB-1:0] == '0 && cmd_last[LB-1:0] == '0); // R5
  AST_WT_NO_CLEAN: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && wt_q |-> cmd_kind != CK_CLEAN); // R7
  AST_BAR_QUIET: assert property (@(posedge clk) disable iff (rst)
    barrier |-> !cmd_valid); // R8
  AST_BAR_PULSE: assert property (@(posedge clk) disable iff (rst)
    barrier && !(req_valid && req_start == req_end) |=> !barrier); // R8
  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> cmd_kind != 2'd3); // R3
endmodule

// File: tb/maint_range_splitter_test.sv
module maint_range_splitter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic        req_wt_override;
  logic [31:0] req_start, req_end;
  logic        cmd_valid, cmd_ready, cmd_done, barrier;
  logic [1:0]  cmd_kind;
  logic [31:0] cmd_addr, cmd_last;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  maint_range_splitter uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_wt_override(req_wt_override), .req_start(req_start), .req_end(req_end),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_last(cmd_last), .cmd_done(cmd_done), .barrier(barrier)
  );

  // {op, wt, start, end, expected command count}
  localparam int NV = 13;
  localparam logic [74:0] VEC [NV] = '{
    {2'd0, 1'b0, 32'h0000_1000, 32'h0000_1100, 8'd1},
    {2'd0, 1'b0, 32'h0000_1004, 32'h0000_1100, 8'd2},
    {2'd0, 1'b0, 32'h0000_1004, 32'h0000_1108, 8'd3},
    {2'd0, 1'b0, 32'h0000_1004, 32'h0000_1010, 8'd1},
    {2'd1, 1'b0, 32'h0000_0FE0, 32'h0000_1040, 8'd2},
    {2'd1, 1'b0, 32'h0000_2000, 32'h0000_2900, 8'd3},
    {2'd1, 1'b0, 32'h0000_3005, 32'h0000_3041, 8'd1},
    {2'd1, 1'b1, 32'h0000_3000, 32'h0000_3100, 8'd0},
    {2'd2, 1'b0, 32'h0000_0FE0, 32'h0000_1020, 8'd4},
    {2'd2, 1'b1, 32'h0000_2000, 32'h0000_2800, 8'd2},
    {2'd0, 1'b0, 32'h0000_1234, 32'h0000_1234, 8'd0},
    {2'd2, 1'b0, 32'h0000_5FF0, 32'h0000_6004, 8'd4},
    {2'd0, 1'b0, 32'h0000_7C10, 32'h0000_8408, 8'd4}
  };

  int          exp_n;
  logic [1:0]  exp_k [64];
  logic [31:0] exp_a [64];
  logic [31:0] exp_l [64];

  task automatic push(input logic [1:0] k, input longint unsigned a, input longint unsigned l);
    exp_k[exp_n] = k;
    exp_a[exp_n] = a[31:0];
    exp_l[exp_n] = l[31:0];
    exp_n++;
  endtask

  // expected command list built from the requirements
  task automatic build_exp(input logic [1:0] op, input logic wt,
                           input longint unsigned s, input longint unsigned e);
    longint unsigned lo, hi, ce, pg, cap;
    exp_n = 0;
    if (s == e) return;
    if (op == 2'd0) begin
      lo = s;
      if (s % 32 != 0) begin push(2'd0, s - s % 32, s - s % 32); lo = s - s % 32 + 32; end
      if (lo < e && e % 32 != 0) push(2'd0, e - e % 32, e - e % 32);
      hi = e - e % 32;
    end else begin
      lo = s - s % 32;
      hi = (e + 31) / 32 * 32;
      if (op == 2'd1 && wt) hi = lo;
    end
    while (lo < hi) begin
      cap = lo + 1024;
      pg  = lo / 4096 * 4096 + 4096;
      ce  = hi;
      if (cap < ce) ce = cap;
      if (pg < ce)  ce = pg;
      if (op == 2'd1) push(2'd1, lo, ce - 32);
      else begin
        if (op == 2'd2 && !wt) push(2'd1, lo, ce - 32);
        push(2'd2, lo, ce - 32);
      end
      lo = ce;
    end
  endtask

  task automatic check(input bit ok, input string req, input longint unsigned act, input longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  bit stall_tog = 1'b0;

  task automatic run_req(input logic [1:0] op, input logic wt,
                         input logic [31:0] s, input logic [31:0] e, input int n_hand);
    int seen;
    bit bar_seen;
    int guard;
    logic [1:0]  k0;
    logic [31:0] a0, l0;
    build_exp(op, wt, {32'd0, s}, {32'd0, e});
    check(exp_n == n_hand, "model count", exp_n, n_hand);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_wt_override = wt; req_start = s; req_end = e;
    @(negedge clk);
    req_valid = 1'b0;
    if (s == e) begin
      check(barrier == 1'b1, "R9 barrier next cycle", barrier, 1);
      check(cmd_valid == 1'b0, "R9 no command", cmd_valid, 0);
    end else begin
      check(req_ready == 1'b0, "R1 busy after accept", req_ready, 0);
    end
    seen = 0; bar_seen = 1'b0; guard = 0;
    while (!bar_seen && guard < 5000) begin
      guard++;
      if (barrier) begin
        bar_seen = 1'b1;
      end else begin
        if (cmd_valid) begin
          k0 = cmd_kind; a0 = cmd_addr; l0 = cmd_last;
          if (seen < exp_n) begin
            if (exp_k[seen] == 2'd0) begin
              check(k0 == exp_k[seen], "R3 R4 line kind", k0, exp_k[seen]);
              check(a0 == exp_a[seen] && l0 == exp_l[seen], "R3 R4 line addr", a0, exp_a[seen]);
            end else begin
              check(k0 == exp_k[seen], "R6 R7 range kind", k0, exp_k[seen]);
              check(a0 == exp_a[seen] && l0 == exp_l[seen], "R2 R5 range bounds", {a0, l0}, {exp_a[seen], exp_l[seen]});
            end
          end else begin
            check(1'b0, "R7 extra command", seen, exp_n);
          end
          seen++;
          stall_tog = ~stall_tog;
          if (stall_tog) begin
            @(negedge clk);
            check(cmd_valid && cmd_kind == k0 && cmd_addr == a0 && cmd_last == l0,
                  "R10 hold under stall", cmd_addr, a0);
          end
          cmd_ready = 1'b1;
          @(negedge clk);
          cmd_ready = 1'b0;
          @(negedge clk);
          check(cmd_valid == 1'b0 && barrier == 1'b0, "R10 wait for done", cmd_valid, 0);
          cmd_done = 1'b1;
          @(negedge clk);
          cmd_done = 1'b0;
        end
        @(negedge clk);
      end
    end
    check(bar_seen, "R8 barrier seen", bar_seen, 1);
    check(seen == exp_n, "R7 command count", seen, exp_n);
    @(negedge clk);
    check(barrier == 1'b0 && req_ready == 1'b1, "R8 single pulse", barrier, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = 2'd0; req_wt_override = 1'b0;
    req_start = '0; req_end = '0; cmd_ready = 1'b0; cmd_done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1 && cmd_valid == 1'b0 && barrier == 1'b0, "R1 reset state",
          {req_ready, cmd_valid, barrier}, 3'b100);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      run_req(VEC[i][74:73], VEC[i][72], VEC[i][71:40], VEC[i][39:8], int'(VEC[i][7:0]));
    end
    // directed: invalidate ignores the override flag (R7)
    run_req(2'd0, 1'b1, 32'h0000_1004, 32'h0000_1108, 3);
    // directed: empty request at an unaligned address, then a back-to-back flush (R9)
    run_req(2'd2, 1'b0, 32'h0000_0011, 32'h0000_0011, 0);
    run_req(2'd2, 1'b0, 32'h0000_0011, 32'h0000_0012, 2);
    // directed: reset while a command waits for done
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_wt_override = 1'b0; req_start = 32'h100; req_end = 32'h200;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(req_ready == 1'b1 && cmd_valid == 1'b0, "R1 reset mid request", cmd_valid, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule